// File: doc/BRIEF.md
# Analog Sample Memory Cell Address Sequencer

This block follows the write position of a circular analog sample store of 64 cells. The pointer moves forward one cell per sample clock. When a trigger is accepted, the block fixes a base cell N, which is the pointer value in the trigger cycle. It then presents the four cells chosen for digitising, one per cycle, so they can be written into an event header. The fixed pattern is the base cell followed by the cells five, six and seven places later. The pointer stands still while those four addresses are being presented. A trigger that arrives during that time is dropped and counted.

A separate checker takes the four header addresses of a received event and a reference cell. One cycle later it classifies the event into one of three classes:
- good: the pattern is intact and starts at the reference cell;
- globally shifted: the pattern is intact but starts at another cell;
- broken sequence: the spacing is wrong, for example when the counter skipped one tick.

Top module: `amu_cell_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_cell` is 0, `seq_valid`, `seq_last` and `ovf_count` are 0, and all checker outputs are 0.
- R2: `wr_cell` rises by one, modulo 64, after every clock edge at which `seq_valid` was low. It holds its value after every edge at which `seq_valid` was high.
- R3: A trigger sampled while `seq_valid` is low latches N = `wr_cell` of that cycle. On the next four cycles `seq_valid` is high and `seq_addr` shows N, N+5, N+6, N+7 in that order. All sums are modulo 64, so the cells after 0x3F wrap to 0x00.
- R4: `seq_last` is high only on the fourth of those cycles, and `seq_valid` falls on the cycle after it.
- R5: A trigger sampled while `seq_valid` is high, including the cycle where `seq_last` is high, leaves the address sequence and `wr_cell` unchanged. It adds one to `ovf_count`, which saturates at 15.
- R6: After an edge at which `hdr_valid` was high, `chk_done` is high for one cycle with exactly one of `chk_good`, `chk_shift`, `chk_badseq` set. Otherwise all four are 0.
- R7: The header pattern is intact when, modulo 64, `hdr_c1`=`hdr_c0`+5, `hdr_c2`=`hdr_c0`+6 and `hdr_c3`=`hdr_c0`+7. An intact header with `hdr_c0`=`hdr_ref` gives `chk_good`.
- R8: An intact header with `hdr_c0` different from `hdr_ref` gives `chk_shift`.
- R9: A header that is not intact gives `chk_badseq`, whatever `hdr_ref` is. Broken sequence wins over shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger request |
| hdr_valid | input | 1 | Received header addresses are present |
| hdr_ref | input | 6 | Expected base cell for the received event |
| hdr_c0 | input | 6 | First received header cell |
| hdr_c1 | input | 6 | Second received header cell |
| hdr_c2 | input | 6 | Third received header cell |
| hdr_c3 | input | 6 | Fourth received header cell |
| wr_cell | output | 6 | Current write pointer |
| seq_valid | output | 1 | A selected cell address is on `seq_addr` |
| seq_last | output | 1 | Fourth address of the event |
| seq_addr | output | 6 | Selected cell address |
| ovf_count | output | 4 | Saturating count of dropped triggers |
| chk_done | output | 1 | Checker result valid |
| chk_good | output | 1 | Header intact and at the reference cell |
| chk_shift | output | 1 | Header intact but moved to another base |
| chk_badseq | output | 1 | Header spacing broken |

## Verification
The risky coincidence is a trigger in the cycle where the fourth address is shown with `seq_last`. In that cycle the block both ends the sequence and sees a new request. The bench sweeps every subset of the four busy cycles with triggers held high, the last cycle included, and follows each burst with idle gaps of different lengths. A per-cycle model then checks that such triggers are dropped and counted, that the pointer restarts only after `seq_valid` falls, and that a trigger on the first idle cycle is taken at once. The checker is swept at the same time over all 64 bases, including the wrapping ones, with intact, shifted, skipped-tick and skipped-and-shifted headers.

// File: rtl/amu_seq_pkg.sv
`timescale 1ns/1ps
package amu_seq_pkg;
    // number of samples taken per event
    localparam int NSAMP = 4;
    localparam int IDX_W = $clog2(NSAMP);
endpackage

// File: rtl/amu_wptr.sv
`timescale 1ns/1ps
module amu_wptr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } wp_t;

    wp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !hold |=> ptr == $past(ptr) + 1'b1); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(ptr)); // R2
endmodule

// File: rtl/amu_readout.sv
`timescale 1ns/1ps
module amu_readout
    import amu_seq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int OFF1   = 5,
    parameter int OFF2   = 6,
    parameter int OFF3   = 7,
    parameter int OVF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [ADDR_W-1:0] wptr,
    output logic              busy,
    output logic              last,
    output logic [ADDR_W-1:0] addr,
    output logic [OVF_W-1:0]  ovf
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSAMP - 1);
    localparam logic [OVF_W-1:0] OVF_MAX  = '1;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [OVF_W-1:0]  ovf;
    } rd_t;

    rd_t st_d, st_q;
    logic [ADDR_W-1:0] off_sel;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
            if (trig && st_q.ovf != OVF_MAX) begin
                st_d.ovf = st_q.ovf + 1'b1;
            end
        end else if (trig) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.base = wptr;
        end
    end

    always_comb begin
        case (st_q.idx)
            2'd1:    off_sel = ADDR_W'(OFF1);
            2'd2:    off_sel = ADDR_W'(OFF2);
            2'd3:    off_sel = ADDR_W'(OFF3);
            default: off_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign last = st_q.busy && (st_q.idx == LAST_IDX);
    assign addr = st_q.base + off_sel;
    assign ovf  = st_q.ovf;

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        last |-> busy); // R4
    AST_BURST_CONT: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy); // R4
    AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy); // R4
    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> addr != $past(addr)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ovf == OVF_MAX) |=> (ovf == OVF_MAX)); // R5
    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (busy && trig && ovf != OVF_MAX) |=> ovf == $past(ovf) + 1'b1); // R5
endmodule

// File: rtl/amu_hdr_check.sv
`timescale 1ns/1ps
module amu_hdr_check
    import amu_seq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int OFF1   = 5,
    parameter int OFF2   = 6,
    parameter int OFF3   = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hv,
    input  logic [ADDR_W-1:0]           ref_cell,
    input  logic [NSAMP-1:0][ADDR_W-1:0] cells,
    output logic                        done,
    output logic                        good,
    output logic                        shift,
    output logic                        badseq
);
    localparam int OFFS [NSAMP] = '{0, OFF1, OFF2, OFF3};

    typedef struct packed {
        logic done;
        logic good;
        logic shift;
        logic bad;
    } ck_t;

    ck_t st_d, st_q;
    logic [NSAMP-1:1] match;
    logic             intact;

    for (genvar i = 1; i < NSAMP; i++) begin : g_cmp
        assign match[i] = (cells[i] == cells[0] + ADDR_W'(OFFS[i]));
    end

    assign intact = &match;

    always_comb begin
        st_d = '0;
        if (hv) begin
            st_d.done = 1'b1;
            if (!intact)                    st_d.bad   = 1'b1;
            else if (cells[0] != ref_cell)  st_d.shift = 1'b1;
            else                            st_d.good  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done   = st_q.done;
    assign good   = st_q.good;
    assign shift  = st_q.shift;
    assign badseq = st_q.bad;

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({good, shift, badseq})); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(good || shift || badseq)); // R6
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        hv |=> done); // R6
endmodule

// File: rtl/amu_cell_sequencer.sv
`timescale 1ns/1ps
module amu_cell_sequencer #(
    parameter int CELLS = 64,
    parameter int OFF1  = 5,
    parameter int OFF2  = 6,
    parameter int OFF3  = 7,
    parameter int OVF_W = 4,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_ref,
    input  logic [ADDR_W-1:0] hdr_c0,
    input  logic [ADDR_W-1:0] hdr_c1,
    input  logic [ADDR_W-1:0] hdr_c2,
    input  logic [ADDR_W-1:0] hdr_c3,
    output logic [ADDR_W-1:0] wr_cell,
    output logic              seq_valid,
    output logic              seq_last,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [OVF_W-1:0]  ovf_count,
    output logic              chk_done,
    output logic              chk_good,
    output logic              chk_shift,
    output logic              chk_badseq
);
    logic busy;

    amu_wptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .hold (busy),
        .ptr  (wr_cell)
    );

    amu_readout #(
        .ADDR_W(ADDR_W), .OFF1(OFF1), .OFF2(OFF2), .OFF3(OFF3), .OVF_W(OVF_W)
    ) u_readout (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .wptr (wr_cell),
        .busy (busy),
        .last (seq_last),
        .addr (seq_addr),
        .ovf  (ovf_count)
    );

    assign seq_valid = busy;

    amu_hdr_check #(
        .ADDR_W(ADDR_W), .OFF1(OFF1), .OFF2(OFF2), .OFF3(OFF3)
    ) u_check (
        .clk      (clk),
        .rst      (rst),
        .hv       (hdr_valid),
        .ref_cell (hdr_ref),
        .cells    ({hdr_c3, hdr_c2, hdr_c1, hdr_c0}),
        .done     (chk_done),
        .good     (chk_good),
        .shift    (chk_shift),
        .badseq   (chk_badseq)
    );

    AST_WPTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        seq_valid |=> $stable(wr_cell)); // R2
    AST_FIRST_IS_BASE: assert property (@(posedge clk) disable iff (rst)
        (!seq_valid && trig) |=> (seq_valid && seq_addr == $past(wr_cell))); // R3
endmodule

// File: tb/amu_cell_sequencer_bench.sv
`timescale 1ns/1ps
module amu_cell_sequencer_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic hdr_valid = 1'b0;
    logic [5:0] hdr_ref = '0, hdr_c0 = '0, hdr_c1 = '0, hdr_c2 = '0, hdr_c3 = '0;
    logic [5:0] wr_cell, seq_addr;
    logic seq_valid, seq_last, chk_done, chk_good, chk_shift, chk_badseq;
    logic [3:0] ovf_count;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int m_wp = 0, m_busy = 0, m_idx = 0, m_base = 0, m_ovf = 0;
    int e_done = 0, e_good = 0, e_shift = 0, e_bad = 0;

    always #2.5 clk = ~clk;

    amu_cell_sequencer u_amu_cell_sequencer (
        .clk(clk), .rst(rst), .trig(trig), .hdr_valid(hdr_valid),
        .hdr_ref(hdr_ref), .hdr_c0(hdr_c0), .hdr_c1(hdr_c1),
        .hdr_c2(hdr_c2), .hdr_c3(hdr_c3), .wr_cell(wr_cell),
        .seq_valid(seq_valid), .seq_last(seq_last), .seq_addr(seq_addr),
        .ovf_count(ovf_count), .chk_done(chk_done), .chk_good(chk_good),
        .chk_shift(chk_shift), .chk_badseq(chk_badseq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int offs(input int i);
        case (i)
            1: return 5;
            2: return 6;
            3: return 7;
            default: return 0;
        endcase
    endfunction

    // one clock: model update from pre-edge inputs, then compare
    task automatic step();
        int ok, dc1, dc2, dc3;
        int n_wp = m_wp, n_busy = m_busy, n_idx = m_idx, n_base = m_base, n_ovf = m_ovf;
        if (m_busy != 0) begin
            if (m_idx == 3) begin n_busy = 0; n_idx = 0; end
            else n_idx = m_idx + 1;
            if (trig && m_ovf < 15) n_ovf = m_ovf + 1;
        end else begin
            n_wp = (m_wp + 1) % 64;
            if (trig) begin n_busy = 1; n_idx = 0; n_base = m_wp; end
        end
        dc1 = (int'(hdr_c1) - int'(hdr_c0) + 64) % 64;
        dc2 = (int'(hdr_c2) - int'(hdr_c0) + 64) % 64;
        dc3 = (int'(hdr_c3) - int'(hdr_c0) + 64) % 64;
        ok = (dc1 == 5 && dc2 == 6 && dc3 == 7);
        e_done = hdr_valid;
        e_bad = hdr_valid && !ok;
        e_shift = hdr_valid && ok && (hdr_c0 != hdr_ref);
        e_good = hdr_valid && ok && (hdr_c0 == hdr_ref);
        @(posedge clk);
        #1;
        m_wp = n_wp; m_busy = n_busy; m_idx = n_idx; m_base = n_base; m_ovf = n_ovf;
        check("R2 wr_cell", wr_cell, m_wp);
        check("R3 seq_valid", seq_valid, m_busy);
        check("R4 seq_last", seq_last, (m_busy != 0 && m_idx == 3));
        if (m_busy != 0) check("R3 seq_addr", seq_addr, (m_base + offs(m_idx)) % 64);
        check("R5 ovf_count", ovf_count, m_ovf);
        check("R6 chk_done", chk_done, e_done);
        check("R7 chk_good", chk_good, e_good);
        check("R8 chk_shift", chk_shift, e_shift);
        check("R9 chk_badseq", chk_badseq, e_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        trig = 1'b1; hdr_valid = 1'b1;
        @(posedge clk); #1;
        // R1: reset holds everything at zero even with inputs active
        check("R1 wr_cell", wr_cell, 0);
        check("R1 seq_valid", seq_valid, 0);
        check("R1 ovf_count", ovf_count, 0);
        check("R1 chk_done", chk_done, 0);
        check("R1 chk_flags", {chk_good, chk_shift, chk_badseq}, 0);
        trig = 1'b0; hdr_valid = 1'b0;
        rst = 1'b0;

        // R2: free running pointer across a wrap
        for (int i = 0; i < 70; i++) step();

        // R3 R4 R5: triggers at varied pointer values, every busy-cycle mask
        for (int it = 0; it < 96; it++) begin
            trig = 1'b1;
            step();
            for (int b = 0; b < 4; b++) begin
                trig = it[b];
                step();
            end
            trig = 1'b0;
            for (int g = 0; g < (it % 5); g++) step();
        end

        // R6..R9: checker sweep over all bases, concurrent with triggers
        for (int base = 0; base < 64; base++) begin
            for (int kind = 0; kind < 5; kind++) begin
                hdr_valid = 1'b1;
                trig = (base + kind) % 3 == 0;
                hdr_c0 = 6'(base);
                hdr_ref = 6'(base);
                case (kind)
                    0: begin hdr_c1 = 6'(base + 5); hdr_c2 = 6'(base + 6); hdr_c3 = 6'(base + 7); end
                    1: begin hdr_c1 = 6'(base + 5); hdr_c2 = 6'(base + 6); hdr_c3 = 6'(base + 7);
                             hdr_ref = 6'(base + 1 + kind * 7); end
                    2: begin hdr_c1 = 6'(base + 5); hdr_c2 = 6'(base + 7); hdr_c3 = 6'(base + 8); end
                    3: begin hdr_c1 = 6'(base + 5); hdr_c2 = 6'(base + 7); hdr_c3 = 6'(base + 8);
                             hdr_ref = 6'(base + 3); end
                    default: begin hdr_c1 = 6'(base + 5); hdr_c2 = 6'(base + 6); hdr_c3 = 6'(base + 8); end
                endcase
                step();
                hdr_valid = 1'b0;
                step();
            end
        end
        trig = 1'b0;
        for (int i = 0; i < 6; i++) step();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule